// File: doc/BRIEF.md
# CAN Transmit Buffer Request Controller

This block holds the control state for a bank of CAN transmit message buffers and decides which one goes to the bit-level transmit engine next. Each buffer carries a valid bit, a transmit-request bit, a completion flag and its identifier with the extended-format flag. Software sets requests, cancels them, enables or disables buffers and clears completion flags through per-buffer strobe vectors. The block gives the engine one frame at a time over a start/done handshake.

Requests are serviced only while the halt bit reads 0, which means the controller takes part in bus traffic. A cancel or disable aimed at the buffer whose frame is on the wire is not applied at once. The cancel is dropped. The disable waits until the frame ends. The identifier fields are locked while a buffer is valid, so software first has to retire the buffer and then rewrite it.

Top module: `can_txq_ctrl`

## Requirements
- R1: After reset all valid, request and completion bits read 0, halt reads 1, `tx_start` and `tx_busy` are 0.
- R2: A request strobe is accepted only for a buffer whose valid bit reads 1 in that cycle. A request to an invalid buffer leaves its request bit at 0 and no frame is started for it.
- R3: When several valid buffers are pending, the lowest-numbered one is started. `tx_start` is a one-cycle pulse that rises two cycles after the cycle in which the buffer became eligible with the engine idle, and `tx_idx` carries the 4-bit buffer number.
- R4: Only one frame is in flight. No further `tx_start` appears until `tx_done` has been seen, and the next start rises two cycles after the `tx_done` cycle.
- R5: A `tx_done` while busy clears the active buffer's request bit and sets its completion flag on the next edge. A `tx_done` while idle has no effect.
- R6: A cancel on a pending buffer that is not in transmission clears its request bit on the next edge, does not set its completion flag and starts no frame for it.
- R7: A cancel on the buffer in transmission is ignored. Its request bit stays 1 until the frame completes, and the completion flag is then set.
- R8: Clearing the valid bit of a buffer not in transmission clears valid and request on the next edge.
- R9: Clearing the valid bit of the buffer in transmission keeps valid at 1 until `tx_done`. Valid then reads 0 and the completion flag reads 1.
- R10: A completion-clear strobe resets the flag. If the strobe and the frame end coincide, the flag reads 1.
- R11: Identifier and extended-flag writes take effect only when the addressed buffer's valid bit is 0. Otherwise they are ignored.
- R12: While halt reads 1 no frame starts and pending requests are kept. Writing halt to 0 lets them start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_we | input | 1 | Write strobe for the halt bit |
| halt_d | input | 1 | Value written to halt |
| halt_o | output | 1 | Halt status (1 = not participating) |
| val_wmask | input | 16 | Buffers whose valid bit is written this cycle |
| val_wdata | input | 16 | Valid value per masked buffer |
| valid_o | output | 16 | Valid bits |
| req_set | input | 16 | Request strobes, one per buffer |
| cancel | input | 16 | Cancel strobes, one per buffer |
| req_o | output | 16 | Transmit-request bits |
| cmp_clr | input | 16 | Completion-flag clear strobes |
| cmp_o | output | 16 | Completion flags |
| id_we | input | 1 | Identifier write strobe |
| id_sel | input | 4 | Buffer addressed by the identifier write |
| id_wdata | input | 29 | Identifier value |
| ide_wdata | input | 1 | Extended-format flag value |
| rd_sel | input | 4 | Buffer selected for identifier readback |
| rd_id | output | 29 | Identifier of the selected buffer |
| rd_ide | output | 1 | Extended flag of the selected buffer |
| tx_start | output | 1 | One-cycle start pulse to the transmit engine |
| tx_idx | output | 4 | Buffer in transmission |
| tx_id | output | 29 | Identifier of the buffer in transmission |
| tx_ide | output | 1 | Extended flag of the buffer in transmission |
| tx_busy | output | 1 | A frame is in flight |
| tx_done | input | 1 | Engine reports the frame finished |

## Verification
A wrong priority decision shows as a wrong `tx_idx` on the very start pulse that follows. A stuck or lost in-flight marker shows as a second `tx_start` before `tx_done`, or as a missing start two cycles after it. A mis-handled cancel or disable on the active buffer shows as a request or valid bit dropping one edge too early, or as a completion flag missing one edge after `tx_done`. A failed identifier lock shows on the readback port in the cycle right after the blocked write.

// File: rtl/ctq_pkg.sv
package ctq_pkg;
  localparam int unsigned CTQ_NBUF_DEF = 16;
  localparam int unsigned CTQ_IDW_DEF  = 29;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_XMIT = 1'b1
  } ctq_seq_e;

  // true when buffer a is allowed to go before buffer b (lower number wins)
  function automatic logic ctq_before(input int unsigned a, input int unsigned b);
    return a < b;
  endfunction
endpackage

// File: rtl/ctq_slot.sv
module ctq_slot #(
  parameter int unsigned IDW = 29
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           val_we,
  input  logic           val_d,
  input  logic           req_set,
  input  logic           cancel,
  input  logic           cmp_clr,
  input  logic           id_we,
  input  logic [IDW-1:0] id_d,
  input  logic           ide_d,
  input  logic           active,
  input  logic           fin,
  output logic           valid_o,
  output logic           req_o,
  output logic           cmp_o,
  output logic           elig_o,
  output logic [IDW-1:0] id_o,
  output logic           ide_o
);
  logic           valid_q, req_q, cmp_q, dpend_q, ide_q;
  logic [IDW-1:0] id_q;

  // named events
  logic ev_dis_req, ev_en_req, ev_drop_now, ev_defer, ev_cancel_ok, ev_accept, ev_id_ok, ev_retire;
  assign ev_dis_req   = val_we && !val_d;
  assign ev_en_req    = val_we && val_d;
  assign ev_drop_now  = ev_dis_req && !active;
  assign ev_defer     = ev_dis_req && active;
  assign ev_cancel_ok = cancel && !active;
  assign ev_accept    = req_set && valid_q && !cancel && !ev_dis_req;
  assign ev_id_ok     = id_we && !valid_q;
  assign ev_retire    = fin && (dpend_q || ev_defer) && !ev_en_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      req_q   <= 1'b0;
      cmp_q   <= 1'b0;
      dpend_q <= 1'b0;
      id_q    <= '0;
      ide_q   <= 1'b0;
    end else begin
      if (ev_drop_now || ev_retire) valid_q <= 1'b0;
      else if (ev_en_req)           valid_q <= 1'b1;

      if (fin || ev_en_req)  dpend_q <= 1'b0;
      else if (ev_defer)     dpend_q <= 1'b1;

      if (fin || ev_cancel_ok || ev_drop_now) req_q <= 1'b0;
      else if (ev_accept)                     req_q <= 1'b1;

      if (fin)          cmp_q <= 1'b1;
      else if (cmp_clr) cmp_q <= 1'b0;

      if (ev_id_ok) begin
        id_q  <= id_d;
        ide_q <= ide_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign req_o   = req_q;
  assign cmp_o   = cmp_q;
  assign id_o    = id_q;
  assign ide_o   = ide_q;
  assign elig_o  = req_q && valid_q && !cancel && !ev_dis_req;

  // R2: an invalid buffer never holds a request
  p_inval_noreq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> !req_q);
  // R5: the frame end sets the completion flag
  p_fin_sets_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> cmp_q);
  // R7: a cancel on the active buffer leaves the request standing
  p_cancel_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cancel && !fin) |=> req_q);
  // R9: a disable on the active buffer is held back
  p_defer_dis_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ev_dis_req && !fin) |=> valid_q);
  // R11: identifier is frozen while valid
  p_id_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> $stable(id_q) && $stable(ide_q));
endmodule

// File: rtl/ctq_pick.sv
module ctq_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  elig,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx = IW'(i);
    end
  end
  assign any = |elig;
endmodule

// File: rtl/ctq_seq.sv
module ctq_seq #(
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_we,
  input  logic          halt_d,
  input  logic          any,
  input  logic [IW-1:0] pick,
  input  logic          tx_done,
  output logic          halt_o,
  output logic          busy_o,
  output logic          start_o,
  output logic          done_ev_o,
  output logic [IW-1:0] act_o
);
  import ctq_pkg::*;

  ctq_seq_e      st_q;
  logic          halt_q, start_q;
  logic [IW-1:0] act_q;
  logic          start_go, done_ev;

  assign done_ev  = (st_q == SQ_XMIT) && tx_done;
  assign start_go = (st_q == SQ_IDLE) && !halt_q && any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      halt_q  <= 1'b1;
      start_q <= 1'b0;
      act_q   <= '0;
    end else begin
      if (halt_we) halt_q <= halt_d;
      start_q <= start_go;
      if (start_go) begin
        st_q  <= SQ_XMIT;
        act_q <= pick;
      end else if (done_ev) begin
        st_q <= SQ_IDLE;
      end
    end
  end

  assign halt_o    = halt_q;
  assign busy_o    = (st_q == SQ_XMIT);
  assign start_o   = start_q;
  assign done_ev_o = done_ev;
  assign act_o     = act_q;

  // R12: halted controller starts nothing
  p_halt_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> !start_q);
  // R4: no new start while a frame is in flight
  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_ev) |=> !start_q);
  // R3: start pulse lasts one cycle and marks the block busy
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy_o ##1 !start_q);
endmodule

// File: rtl/can_txq_ctrl.sv
module can_txq_ctrl #(
  parameter int unsigned NBUF = ctq_pkg::CTQ_NBUF_DEF,
  parameter int unsigned IDW  = ctq_pkg::CTQ_IDW_DEF,
  localparam int unsigned IW  = $clog2(NBUF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_we,
  input  logic            halt_d,
  output logic            halt_o,
  input  logic [NBUF-1:0] val_wmask,
  input  logic [NBUF-1:0] val_wdata,
  output logic [NBUF-1:0] valid_o,
  input  logic [NBUF-1:0] req_set,
  input  logic [NBUF-1:0] cancel,
  output logic [NBUF-1:0] req_o,
  input  logic [NBUF-1:0] cmp_clr,
  output logic [NBUF-1:0] cmp_o,
  input  logic            id_we,
  input  logic [IW-1:0]   id_sel,
  input  logic [IDW-1:0]  id_wdata,
  input  logic            ide_wdata,
  input  logic [IW-1:0]   rd_sel,
  output logic [IDW-1:0]  rd_id,
  output logic            rd_ide,
  output logic            tx_start,
  output logic [IW-1:0]   tx_idx,
  output logic [IDW-1:0]  tx_id,
  output logic            tx_ide,
  output logic            tx_busy,
  input  logic            tx_done
);
  logic [NBUF-1:0] elig, active, fin, low_m;
  logic [IDW-1:0]  id_arr [NBUF];
  logic [NBUF-1:0] ide_arr;
  logic            any, busy, done_ev;
  logic [IW-1:0]   pick, act;

  for (genvar gi = 0; gi < NBUF; gi++) begin : g_slot
    assign active[gi] = busy && (act == IW'(gi));
    assign fin[gi]    = done_ev && (act == IW'(gi));
    ctq_slot #(.IDW(IDW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .val_we (val_wmask[gi]),
      .val_d  (val_wdata[gi]),
      .req_set(req_set[gi]),
      .cancel (cancel[gi]),
      .cmp_clr(cmp_clr[gi]),
      .id_we  (id_we && (id_sel == IW'(gi))),
      .id_d   (id_wdata),
      .ide_d  (ide_wdata),
      .active (active[gi]),
      .fin    (fin[gi]),
      .valid_o(valid_o[gi]),
      .req_o  (req_o[gi]),
      .cmp_o  (cmp_o[gi]),
      .elig_o (elig[gi]),
      .id_o   (id_arr[gi]),
      .ide_o  (ide_arr[gi])
    );
    assign low_m[gi] = ctq_pkg::ctq_before(gi, 32'(tx_idx));
  end

  ctq_pick #(.N(NBUF), .IW(IW)) u_pick (
    .elig(elig),
    .any (any),
    .idx (pick)
  );

  ctq_seq #(.IW(IW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_we  (halt_we),
    .halt_d   (halt_d),
    .any      (any),
    .pick     (pick),
    .tx_done  (tx_done),
    .halt_o   (halt_o),
    .busy_o   (busy),
    .start_o  (tx_start),
    .done_ev_o(done_ev),
    .act_o    (act)
  );

  assign tx_busy = busy;
  assign tx_idx  = act;
  assign tx_id   = id_arr[act];
  assign tx_ide  = ide_arr[act];
  assign rd_id   = id_arr[rd_sel];
  assign rd_ide  = ide_arr[rd_sel];

  // R3: the started buffer is valid and requested
  p_start_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> valid_o[tx_idx] && req_o[tx_idx]);
  // R3: no lower-numbered buffer was eligible when the choice was made
  p_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (($past(elig) & low_m) == '0));
endmodule

// File: tb/sim_can_txq_ctrl.sv
module sim_can_txq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_we = 0, halt_d = 0, halt_o;
  logic [N-1:0] val_wmask = '0, val_wdata = '0, valid_o;
  logic [N-1:0] req_set = '0, cancel = '0, req_o, cmp_clr = '0, cmp_o;
  logic id_we = 0, ide_wdata = 0, rd_ide, tx_start, tx_ide, tx_busy, tx_done = 0;
  logic [3:0] id_sel = '0, rd_sel = '0, tx_idx;
  logic [28:0] id_wdata = '0, rd_id, tx_id;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_txq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .halt_we(halt_we), .halt_d(halt_d), .halt_o(halt_o),
    .val_wmask(val_wmask), .val_wdata(val_wdata), .valid_o(valid_o),
    .req_set(req_set), .cancel(cancel), .req_o(req_o),
    .cmp_clr(cmp_clr), .cmp_o(cmp_o),
    .id_we(id_we), .id_sel(id_sel), .id_wdata(id_wdata), .ide_wdata(ide_wdata),
    .rd_sel(rd_sel), .rd_id(rd_id), .rd_ide(rd_ide),
    .tx_start(tx_start), .tx_idx(tx_idx), .tx_id(tx_id), .tx_ide(tx_ide),
    .tx_busy(tx_busy), .tx_done(tx_done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    halt_we = 0; val_wmask = '0; val_wdata = '0; req_set = '0; cancel = '0;
    cmp_clr = '0; id_we = 0; tx_done = 0;
  endtask

  function automatic logic [28:0] id_pat(input int i, input int salt);
    return 29'((i * 32'h0123_4567) ^ (salt * 32'h00A5_5A5A) ^ i);
  endfunction

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  // wait for a start, check index and latency, then finish the frame
  task automatic serve(input int exp_idx, input int exp_wait, input string tag, input int hold);
    int n = 0;
    while (!tx_start && n < 20) begin cyc(); n++; end
    chk(tx_start == 1'b1, {tag, " start seen"}, tx_start, 1);
    chk(int'(tx_idx) == exp_idx, {tag, " start index"}, tx_idx, exp_idx);
    chk(n == exp_wait, {tag, " start latency"}, n, exp_wait);
    cyc();
    chk(!tx_start && tx_busy, "R3 start is one cycle, busy held", {tx_start, tx_busy}, 2'b01);
    for (int k = 0; k < hold; k++) cyc();
    tx_done = 1;
    cyc();
    chk(!req_o[exp_idx] && cmp_o[exp_idx], "R5 done clears req sets cmp",
        {req_o[exp_idx], cmp_o[exp_idx]}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    // R1 reset state
    chk(valid_o == '0 && req_o == '0 && cmp_o == '0, "R1 bits clear", {valid_o, req_o, cmp_o}, 0);
    chk(halt_o == 1'b1 && !tx_start && !tx_busy, "R1 halt/start/busy", {halt_o, tx_start, tx_busy}, 3'b100);

    // R11 identifier write sweep
    for (int i = 0; i < N; i++) begin
      id_we = 1; id_sel = 4'(i); id_wdata = id_pat(i, 1); ide_wdata = i[0];
      cyc();
      rd_sel = 4'(i); #1;
      chk(rd_id == id_pat(i, 1) && rd_ide == i[0], "R11 write while invalid", rd_id, id_pat(i, 1));
      val_wmask[i] = 1; val_wdata[i] = 1;
      cyc();
      id_we = 1; id_sel = 4'(i); id_wdata = id_pat(i, 2); ide_wdata = ~i[0];
      cyc();
      #1;
      chk(rd_id == id_pat(i, 1) && rd_ide == i[0], "R11 write while valid ignored", rd_id, id_pat(i, 1));
    end
    chk(valid_o == '1, "R11 all valid", valid_o, 16'hFFFF);

    // R2 request to invalid buffer (halt still 1)
    val_wmask[5] = 1; val_wdata[5] = 0;
    cyc();
    req_set[5] = 1;
    cyc();
    chk(!req_o[5], "R2 request on invalid dropped", req_o[5], 0);
    // R8 disable idle pending buffer
    req_set[6] = 1;
    cyc();
    chk(req_o[6], "R2 request on valid accepted", req_o[6], 1);
    val_wmask[6] = 1; val_wdata[6] = 0;
    cyc();
    chk(!valid_o[6] && !req_o[6], "R8 idle disable immediate", {valid_o[6], req_o[6]}, 0);
    halt_we = 1; halt_d = 0;
    cyc();
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk(!tx_start, "R2 no start for dropped request", tx_start, 0);
    end

    // R3/R4/R12 lowest-first sweeps over several request patterns
    for (int p = 0; p < 5; p++) begin
      logic [N-1:0] m;
      m = (p == 0) ? 16'hFFFF : (p == 1) ? 16'h8001 : (p == 2) ? 16'h0A50 :
          (p == 3) ? 16'h4000 : 16'h3C3C;
      halt_we = 1; halt_d = 1; val_wmask = '1; val_wdata = '1; cmp_clr = '1;
      cyc();
      req_set = m;
      cyc();
      for (int k = 0; k < 3; k++) begin
        cyc();
        chk(!tx_start && req_o == m, "R12 halted keeps requests, no start", req_o, m);
      end
      halt_we = 1; halt_d = 0;
      cyc();
      begin
        logic [N-1:0] rem;
        rem = m;
        while (rem != '0) begin
          int e;
          e = lowest(rem);
          serve(e, 1, "R3 R4 lowest first", p);
          rem[e] = 1'b0;
        end
      end
      chk(cmp_o == m && req_o == '0, "R5 pattern done flags", cmp_o, m);
    end

    // R10 partial clear
    cmp_clr = 16'h00FF;
    cyc();
    chk(cmp_o == 16'h3C00, "R10 clear strobe", cmp_o, 16'h3C00);

    // R5 done while idle has no effect
    cmp_clr = '1;
    cyc();
    tx_done = 1;
    cyc();
    cyc();
    chk(cmp_o == '0 && !tx_start && !tx_busy, "R5 idle done ignored", cmp_o, 0);

    // R6 cancel before start
    halt_we = 1; halt_d = 1;
    cyc();
    req_set[3] = 1;
    cyc();
    cancel[3] = 1;
    cyc();
    chk(!req_o[3] && !cmp_o[3], "R6 cancel clears req no cmp", {req_o[3], cmp_o[3]}, 0);
    halt_we = 1; halt_d = 0;
    cyc();
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk(!tx_start, "R6 cancelled request not started", tx_start, 0);
    end

    // R7 cancel during transmission, R4 lower request waits
    req_set[7] = 1;
    cyc();
    while (!tx_start) cyc();
    chk(tx_idx == 4'd7 && tx_id == id_pat(7, 1), "R7 start on 7 with its id", tx_id, id_pat(7, 1));
    cancel[7] = 1; req_set[0] = 1;
    cyc();
    chk(req_o[7] && req_o[0], "R7 cancel on active ignored", {req_o[7], req_o[0]}, 2'b11);
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk(!tx_start, "R4 no start while busy", tx_start, 0);
    end
    tx_done = 1;
    cyc();
    chk(!req_o[7] && cmp_o[7], "R7 frame completed", {req_o[7], cmp_o[7]}, 2'b01);
    serve(0, 1, "R4 next start after done", 1);

    // R9 disable during transmission
    req_set[9] = 1;
    cyc();
    while (!tx_start) cyc();
    val_wmask[9] = 1; val_wdata[9] = 0;
    cyc();
    chk(valid_o[9] && req_o[9], "R9 disable held back", {valid_o[9], req_o[9]}, 2'b11);
    id_we = 1; id_sel = 4'd9; id_wdata = id_pat(9, 3);
    cyc();
    rd_sel = 4'd9; #1;
    chk(rd_id == id_pat(9, 1), "R11 pending-disable still locks id", rd_id, id_pat(9, 1));
    tx_done = 1;
    cyc();
    chk(!valid_o[9] && cmp_o[9] && !req_o[9], "R9 disable applied at end",
        {valid_o[9], cmp_o[9], req_o[9]}, 3'b010);

    // R10 set wins over clear at frame end
    req_set[2] = 1;
    cyc();
    while (!tx_start) cyc();
    cyc();
    tx_done = 1; cmp_clr[2] = 1;
    cyc();
    chk(cmp_o[2], "R10 set wins over clear", cmp_o[2], 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule